// File: doc/BRIEF.md
# Multi-View Integer Register File

This block holds the integer architectural state of a processor core: 64 general registers of 64 bits, a bank of 64 control registers, a 32-bit status word, the program counter and the instruction-set-mode bit. Several access paths share that storage. A full-width path reads and writes any general register by a 6-bit index. A half-width path sees only the lowest 16 registers through a 4-bit index: it returns the low 32 bits on a read, and on a write it widens the 32-bit value by copying its sign bit.

The control-register path treats index 0 as a window onto the status word, not as storage of its own. Six status flags can also be read and written one bit at a time through a 3-bit flag selector. A program-counter write divides its value in two: bit 0 goes to the mode bit, and the remaining bits go to the counter with bit 0 forced to zero. All reads are combinational. Every write is registered on the rising clock edge.

Top module: `multiview_regfile`

## Requirements
- R1: Reading general register 63 on the full-width path always gives zero. A write to register 63 leaves every readable value unchanged.
- R2: A full-width write to register n (n not 63) appears on the full-width read of n in the cycle after the write edge. Reads are combinational on the current index.
- R3: A half-width read of index n (0..15) returns bits 31:0 of general register n.
- R4: A half-width write of value v to index n stores v into bits 31:0 of register n, and stores copies of v bit 31 into bits 63:32.
- R5: When the full-width and half-width paths write the same register in one cycle, the half-width value is the one kept.
- R6: A control read of index 0 returns the status word in bits 31:0 and zero in bits 63:32. A control write to index 0 loads bits 31:0 of the data into the status word and discards bits 63:32.
- R7: Control indices 1..63 are independent 64-bit registers that keep what was last written to them.
- R8: Flag selector codes map to status bits as follows: 0 maps to bit 14 (FP bank), 1 to bit 13 (transfer size), 2 to bit 12 (precision), 3 to bit 9 (divide M), 4 to bit 8 (divide Q), and 5 to bit 1 (MAC saturation). Codes 6 and 7 read as 0, and a write with either code has no effect.
- R9: A flag write alters only the selected status bit.
- R10: If a control write to index 0 and a flag write happen in the same cycle, the selected bit takes the flag value and the other bits take the control data.
- R11: A program-counter write of value v makes the counter read v with bit 0 cleared, and makes the mode bit equal v bit 0.
- R12: The mode bit changes only on a program-counter write.
- R13: A synchronous reset clears every general and control register, the status word, the counter and the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wideRdIdx | input | 6 | Full-width read index |
| wideRdData | output | 64 | Full-width read data |
| wideWrEn | input | 1 | Full-width write enable |
| wideWrIdx | input | 6 | Full-width write index |
| wideWrData | input | 64 | Full-width write data |
| narrowRdIdx | input | 4 | Half-width read index |
| narrowRdData | output | 32 | Half-width read data |
| narrowWrEn | input | 1 | Half-width write enable |
| narrowWrIdx | input | 4 | Half-width write index |
| narrowWrData | input | 32 | Half-width write data |
| ctlRdIdx | input | 6 | Control read index |
| ctlRdData | output | 64 | Control read data |
| ctlWrEn | input | 1 | Control write enable |
| ctlWrIdx | input | 6 | Control write index |
| ctlWrData | input | 64 | Control write data |
| flagRdSel | input | 3 | Flag read selector |
| flagRdVal | output | 1 | Selected flag value |
| flagWrEn | input | 1 | Flag write enable |
| flagWrSel | input | 3 | Flag write selector |
| flagWrVal | input | 1 | Flag write value |
| pcWrEn | input | 1 | Program-counter write enable |
| pcWrData | input | 64 | Program-counter write value |
| pcOut | output | 64 | Current program counter |
| modeOut | output | 1 | Current instruction-set-mode bit |

## Verification
All reads are combinational, so a corrupted register, status bit or mode bit becomes visible at a read port in the same cycle the bench selects it. The only delay is how long the bench takes to point an index at the damaged entry. The bench keeps the read indices clustered on the few entries that the writes hit. A misrouted write, a lost sign extension or a flag that leaks into a neighbouring bit therefore shows up within a cycle or two. Collisions between the two general-register paths, and between a status write and a flag write, are driven on purpose. A wrong precedence then reads back as the wrong value on the very next cycle.

// File: rtl/mvrf_pkg.sv
package mvrf_pkg;

  localparam int FLAG_SEL_W = 3;
  localparam int FLAG_POS_W = 5;

  // Status-word bit positions of the single-bit flags
  localparam logic [FLAG_POS_W-1:0] POS_FPBANK = 5'd14;
  localparam logic [FLAG_POS_W-1:0] POS_XSIZE  = 5'd13;
  localparam logic [FLAG_POS_W-1:0] POS_FPPREC = 5'd12;
  localparam logic [FLAG_POS_W-1:0] POS_DIVM   = 5'd9;
  localparam logic [FLAG_POS_W-1:0] POS_DIVQ   = 5'd8;
  localparam logic [FLAG_POS_W-1:0] POS_MACSAT = 5'd1;

  typedef struct packed {
    logic                  ok;
    logic [FLAG_POS_W-1:0] pos;
  } flagLocT;

  // Write strobes from control to datapath
  typedef struct packed {
    logic                  wideWe;
    logic                  narrowWe;
    logic                  crWe;
    logic                  srWe;
    logic                  flagWe;
    logic [FLAG_POS_W-1:0] flagPos;
    logic                  pcWe;
  } wrStrobeT;

  function automatic flagLocT flagLocate(input logic [FLAG_SEL_W-1:0] sel);
    flagLocT loc;
    loc.ok = 1'b1;
    case (sel)
      3'd0:    loc.pos = POS_FPBANK;
      3'd1:    loc.pos = POS_XSIZE;
      3'd2:    loc.pos = POS_FPPREC;
      3'd3:    loc.pos = POS_DIVM;
      3'd4:    loc.pos = POS_DIVQ;
      3'd5:    loc.pos = POS_MACSAT;
      default: begin
        loc.ok  = 1'b0;
        loc.pos = '0;
      end
    endcase
    return loc;
  endfunction

endpackage

// File: rtl/mvrf_ctrl.sv
module mvrf_ctrl
  import mvrf_pkg::*;
#(
  parameter int NUM_GPR = 64,
  parameter int NUM_CR  = 64,
  parameter int NAR_CNT = 16
) (
  input  logic                          wideWrEn,
  input  logic [$clog2(NUM_GPR)-1:0]    wideWrIdx,
  input  logic                          narrowWrEn,
  input  logic [$clog2(NAR_CNT)-1:0]    narrowWrIdx,
  input  logic                          ctlWrEn,
  input  logic [$clog2(NUM_CR)-1:0]     ctlWrIdx,
  input  logic                          flagWrEn,
  input  logic [FLAG_SEL_W-1:0]         flagWrSel,
  input  logic [FLAG_SEL_W-1:0]         flagRdSel,
  input  logic                          pcWrEn,
  output wrStrobeT                      strobe,
  output logic                          flagRdOk,
  output logic [FLAG_POS_W-1:0]         flagRdPos
);

  localparam int GPR_IDX_W = $clog2(NUM_GPR);
  localparam int NAR_IDX_W = $clog2(NAR_CNT);
  localparam int CR_IDX_W  = $clog2(NUM_CR);
  localparam logic [GPR_IDX_W-1:0] ZERO_IDX = GPR_IDX_W'(NUM_GPR - 1);
  localparam logic [CR_IDX_W-1:0]  SR_IDX   = '0;

  logic [GPR_IDX_W-1:0] narrowIdxWide;
  logic                 sameTarget;
  flagLocT              wrLoc;
  flagLocT              rdLoc;

  assign narrowIdxWide = {{(GPR_IDX_W-NAR_IDX_W){1'b0}}, narrowWrIdx};
  assign sameTarget    = narrowWrEn && (narrowIdxWide == wideWrIdx);
  assign wrLoc         = flagLocate(flagWrSel);
  assign rdLoc         = flagLocate(flagRdSel);

  always_comb begin
    strobe          = '0;
    // half-width path wins a collision; top entry is never written
    strobe.wideWe   = wideWrEn && (wideWrIdx != ZERO_IDX) && !sameTarget;
    strobe.narrowWe = narrowWrEn && (narrowIdxWide != ZERO_IDX);
    // control index 0 is redirected to the status word
    strobe.srWe     = ctlWrEn && (ctlWrIdx == SR_IDX);
    strobe.crWe     = ctlWrEn && (ctlWrIdx != SR_IDX);
    strobe.flagWe   = flagWrEn && wrLoc.ok;
    strobe.flagPos  = wrLoc.pos;
    strobe.pcWe     = pcWrEn;
  end

  assign flagRdOk  = rdLoc.ok;
  assign flagRdPos = rdLoc.pos;

endmodule

// File: rtl/mvrf_datapath.sv
module mvrf_datapath
  import mvrf_pkg::*;
#(
  parameter int NUM_GPR = 64,
  parameter int GPR_W   = 64,
  parameter int NAR_W   = 32,
  parameter int NAR_CNT = 16,
  parameter int NUM_CR  = 64,
  parameter int SR_W    = 32,
  parameter int PC_W    = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  wrStrobeT                    strobe,
  input  logic [$clog2(NUM_GPR)-1:0]  wideRdIdx,
  input  logic [$clog2(NUM_GPR)-1:0]  wideWrIdx,
  input  logic [GPR_W-1:0]            wideWrData,
  input  logic [$clog2(NAR_CNT)-1:0]  narrowRdIdx,
  input  logic [$clog2(NAR_CNT)-1:0]  narrowWrIdx,
  input  logic [NAR_W-1:0]            narrowWrData,
  input  logic [$clog2(NUM_CR)-1:0]   ctlRdIdx,
  input  logic [$clog2(NUM_CR)-1:0]   ctlWrIdx,
  input  logic [GPR_W-1:0]            ctlWrData,
  input  logic                        flagWrVal,
  input  logic                        flagRdOk,
  input  logic [FLAG_POS_W-1:0]       flagRdPos,
  input  logic [PC_W-1:0]             pcWrData,
  output logic [GPR_W-1:0]            wideRdData,
  output logic [NAR_W-1:0]            narrowRdData,
  output logic [GPR_W-1:0]            ctlRdData,
  output logic                        flagRdVal,
  output logic [SR_W-1:0]             statusQ,
  output logic [PC_W-1:0]             pcOut,
  output logic                        modeOut
);

  localparam int GPR_IDX_W = $clog2(NUM_GPR);
  localparam int NAR_IDX_W = $clog2(NAR_CNT);
  localparam int CR_IDX_W  = $clog2(NUM_CR);
  localparam int EXT_W     = GPR_W - NAR_W;
  localparam int SR_PAD_W  = GPR_W - SR_W;
  localparam logic [GPR_IDX_W-1:0] ZERO_IDX = GPR_IDX_W'(NUM_GPR - 1);
  localparam logic [CR_IDX_W-1:0]  SR_IDX   = '0;

  logic [GPR_W-1:0] gprMem [NUM_GPR];
  logic [GPR_W-1:0] crMem  [NUM_CR];
  logic [SR_W-1:0]  srNext;
  logic [PC_W-1:0]  pcQ;
  logic             modeQ;

  logic [GPR_IDX_W-1:0] narrowWrIdxW;
  logic [GPR_IDX_W-1:0] narrowRdIdxW;
  logic [GPR_W-1:0]     narrowExt;

  assign narrowWrIdxW = {{(GPR_IDX_W-NAR_IDX_W){1'b0}}, narrowWrIdx};
  assign narrowRdIdxW = {{(GPR_IDX_W-NAR_IDX_W){1'b0}}, narrowRdIdx};
  assign narrowExt    = {{EXT_W{narrowWrData[NAR_W-1]}}, narrowWrData};

  // general registers: two write paths, half-width applied last
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_GPR; i++) gprMem[i] <= '0;
    end else begin
      if (strobe.wideWe)   gprMem[wideWrIdx]    <= wideWrData;
      if (strobe.narrowWe) gprMem[narrowWrIdxW] <= narrowExt;
    end
  end

  // control registers (entry 0 is not used as storage)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CR; i++) crMem[i] <= '0;
    end else if (strobe.crWe) begin
      crMem[ctlWrIdx] <= ctlWrData;
    end
  end

  // status word: bulk load, then the single flag overrides its bit
  always_comb begin
    srNext = statusQ;
    if (strobe.srWe)   srNext = ctlWrData[SR_W-1:0];
    if (strobe.flagWe) srNext[strobe.flagPos] = flagWrVal;
  end

  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= srNext;
  end

  // program counter and mode bit
  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ   <= '0;
      modeQ <= 1'b0;
    end else if (strobe.pcWe) begin
      pcQ   <= {pcWrData[PC_W-1:1], 1'b0};
      modeQ <= pcWrData[0];
    end
  end

  assign pcOut   = pcQ;
  assign modeOut = modeQ;

  // read side
  assign wideRdData   = (wideRdIdx == ZERO_IDX) ? '0 : gprMem[wideRdIdx];
  assign narrowRdData = gprMem[narrowRdIdxW][NAR_W-1:0];
  assign ctlRdData    = (ctlRdIdx == SR_IDX) ? {{SR_PAD_W{1'b0}}, statusQ}
                                             : crMem[ctlRdIdx];
  assign flagRdVal    = flagRdOk & statusQ[flagRdPos];

endmodule

// File: rtl/multiview_regfile.sv
module multiview_regfile
  import mvrf_pkg::*;
#(
  parameter int NUM_GPR = 64,
  parameter int GPR_W   = 64,
  parameter int NAR_W   = 32,
  parameter int NAR_CNT = 16,
  parameter int NUM_CR  = 64,
  parameter int SR_W    = 32,
  parameter int PC_W    = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(NUM_GPR)-1:0]  wideRdIdx,
  output logic [GPR_W-1:0]            wideRdData,
  input  logic                        wideWrEn,
  input  logic [$clog2(NUM_GPR)-1:0]  wideWrIdx,
  input  logic [GPR_W-1:0]            wideWrData,
  input  logic [$clog2(NAR_CNT)-1:0]  narrowRdIdx,
  output logic [NAR_W-1:0]            narrowRdData,
  input  logic                        narrowWrEn,
  input  logic [$clog2(NAR_CNT)-1:0]  narrowWrIdx,
  input  logic [NAR_W-1:0]            narrowWrData,
  input  logic [$clog2(NUM_CR)-1:0]   ctlRdIdx,
  output logic [GPR_W-1:0]            ctlRdData,
  input  logic                        ctlWrEn,
  input  logic [$clog2(NUM_CR)-1:0]   ctlWrIdx,
  input  logic [GPR_W-1:0]            ctlWrData,
  input  logic [FLAG_SEL_W-1:0]       flagRdSel,
  output logic                        flagRdVal,
  input  logic                        flagWrEn,
  input  logic [FLAG_SEL_W-1:0]       flagWrSel,
  input  logic                        flagWrVal,
  input  logic                        pcWrEn,
  input  logic [PC_W-1:0]             pcWrData,
  output logic [PC_W-1:0]             pcOut,
  output logic                        modeOut
);

  wrStrobeT              strobe;
  logic                  flagRdOk;
  logic [FLAG_POS_W-1:0] flagRdPos;
  logic [SR_W-1:0]       statusQ;

  mvrf_ctrl #(
    .NUM_GPR(NUM_GPR), .NUM_CR(NUM_CR), .NAR_CNT(NAR_CNT)
  ) u_ctrl (
    .wideWrEn    (wideWrEn),
    .wideWrIdx   (wideWrIdx),
    .narrowWrEn  (narrowWrEn),
    .narrowWrIdx (narrowWrIdx),
    .ctlWrEn     (ctlWrEn),
    .ctlWrIdx    (ctlWrIdx),
    .flagWrEn    (flagWrEn),
    .flagWrSel   (flagWrSel),
    .flagRdSel   (flagRdSel),
    .pcWrEn      (pcWrEn),
    .strobe      (strobe),
    .flagRdOk    (flagRdOk),
    .flagRdPos   (flagRdPos)
  );

  mvrf_datapath #(
    .NUM_GPR(NUM_GPR), .GPR_W(GPR_W), .NAR_W(NAR_W), .NAR_CNT(NAR_CNT),
    .NUM_CR(NUM_CR), .SR_W(SR_W), .PC_W(PC_W)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .wideRdIdx    (wideRdIdx),
    .wideWrIdx    (wideWrIdx),
    .wideWrData   (wideWrData),
    .narrowRdIdx  (narrowRdIdx),
    .narrowWrIdx  (narrowWrIdx),
    .narrowWrData (narrowWrData),
    .ctlRdIdx     (ctlRdIdx),
    .ctlWrIdx     (ctlWrIdx),
    .ctlWrData    (ctlWrData),
    .flagWrVal    (flagWrVal),
    .flagRdOk     (flagRdOk),
    .flagRdPos    (flagRdPos),
    .pcWrData     (pcWrData),
    .wideRdData   (wideRdData),
    .narrowRdData (narrowRdData),
    .ctlRdData    (ctlRdData),
    .flagRdVal    (flagRdVal),
    .statusQ      (statusQ),
    .pcOut        (pcOut),
    .modeOut      (modeOut)
  );

endmodule

// File: rtl/mvrf_checker.sv
module mvrf_checker #(
  parameter int GPR_IDX_W = 6,
  parameter int NAR_IDX_W = 4,
  parameter int CR_IDX_W  = 6,
  parameter int GPR_W     = 64,
  parameter int NAR_W     = 32,
  parameter int SR_W      = 32,
  parameter int PC_W      = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic [GPR_IDX_W-1:0] wideRdIdx,
  input logic [GPR_W-1:0]     wideRdData,
  input logic                 wideWrEn,
  input logic [GPR_IDX_W-1:0] wideWrIdx,
  input logic [GPR_W-1:0]     wideWrData,
  input logic                 narrowWrEn,
  input logic [NAR_IDX_W-1:0] narrowWrIdx,
  input logic [NAR_W-1:0]     narrowWrData,
  input logic [CR_IDX_W-1:0]  ctlRdIdx,
  input logic [GPR_W-1:0]     ctlRdData,
  input logic                 ctlWrEn,
  input logic [CR_IDX_W-1:0]  ctlWrIdx,
  input logic                 flagWrEn,
  input logic [2:0]           flagWrSel,
  input logic                 flagWrVal,
  input logic                 pcWrEn,
  input logic [PC_W-1:0]      pcWrData,
  input logic [PC_W-1:0]      pcOut,
  input logic                 modeOut,
  input logic [SR_W-1:0]      statusQ
);

  localparam logic [GPR_IDX_W-1:0] TOP_IDX = '1;
  localparam int EXT_W = GPR_W - NAR_W;
  localparam int PAD_W = GPR_W - SR_W;

  logic [GPR_IDX_W-1:0] narrowIdxW;
  logic [SR_W-1:0]      flagMask;
  logic                 flagSelOk;
  logic                 srCtlWr;

  assign narrowIdxW = {{(GPR_IDX_W-NAR_IDX_W){1'b0}}, narrowWrIdx};
  assign srCtlWr    = ctlWrEn && (ctlWrIdx == '0);

  always_comb begin
    flagMask = '0;
    case (flagWrSel)
      3'd0: flagMask[14] = 1'b1;
      3'd1: flagMask[13] = 1'b1;
      3'd2: flagMask[12] = 1'b1;
      3'd3: flagMask[9]  = 1'b1;
      3'd4: flagMask[8]  = 1'b1;
      3'd5: flagMask[1]  = 1'b1;
      default: flagMask = '0;
    endcase
  end
  assign flagSelOk = (flagMask != '0);

  a_r1_top_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (wideRdIdx == TOP_IDX) |-> (wideRdData == '0));

  a_r2_wide_write_seen: assert property (@(posedge clk) disable iff (rst)
    (wideWrEn && (wideWrIdx != TOP_IDX) && !(narrowWrEn && (narrowIdxW == wideWrIdx)))
    |=> ((wideRdIdx != $past(wideWrIdx)) || (wideRdData == $past(wideWrData))));

  a_r4_narrow_sign_ext: assert property (@(posedge clk) disable iff (rst)
    narrowWrEn |=> ((wideRdIdx != $past(narrowIdxW)) ||
      (wideRdData == {{EXT_W{$past(narrowWrData[NAR_W-1])}}, $past(narrowWrData)})));

  a_r6_status_window: assert property (@(posedge clk) disable iff (rst)
    (ctlRdIdx == '0) |-> (ctlRdData == {{PAD_W{1'b0}}, statusQ}));

  a_r9_flag_isolated: assert property (@(posedge clk) disable iff (rst)
    (flagWrEn && flagSelOk && !srCtlWr)
    |=> (((statusQ ^ $past(statusQ)) & ~$past(flagMask)) == '0));

  a_r10_flag_priority: assert property (@(posedge clk) disable iff (rst)
    (flagWrEn && flagSelOk)
    |=> ((statusQ & $past(flagMask)) == ($past(flagWrVal) ? $past(flagMask) : '0)));

  a_r11_pc_split: assert property (@(posedge clk) disable iff (rst)
    pcWrEn |=> ((pcOut == {$past(pcWrData[PC_W-1:1]), 1'b0}) && (modeOut == $past(pcWrData[0]))));

  a_r12_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !pcWrEn |=> $stable(modeOut));

  a_r13_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((pcOut == '0) && !modeOut && (statusQ == '0)));

endmodule

bind multiview_regfile mvrf_checker #(
  .GPR_IDX_W($clog2(NUM_GPR)), .NAR_IDX_W($clog2(NAR_CNT)), .CR_IDX_W($clog2(NUM_CR)),
  .GPR_W(GPR_W), .NAR_W(NAR_W), .SR_W(SR_W), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst(rst),
  .wideRdIdx(wideRdIdx), .wideRdData(wideRdData),
  .wideWrEn(wideWrEn), .wideWrIdx(wideWrIdx), .wideWrData(wideWrData),
  .narrowWrEn(narrowWrEn), .narrowWrIdx(narrowWrIdx), .narrowWrData(narrowWrData),
  .ctlRdIdx(ctlRdIdx), .ctlRdData(ctlRdData),
  .ctlWrEn(ctlWrEn), .ctlWrIdx(ctlWrIdx),
  .flagWrEn(flagWrEn), .flagWrSel(flagWrSel), .flagWrVal(flagWrVal),
  .pcWrEn(pcWrEn), .pcWrData(pcWrData),
  .pcOut(pcOut), .modeOut(modeOut), .statusQ(statusQ)
);

// File: tb/sim_multiview_regfile.sv
module sim_multiview_regfile;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [5:0]  wideRdIdx, wideWrIdx, ctlRdIdx, ctlWrIdx;
  logic [63:0] wideRdData, wideWrData, ctlRdData, ctlWrData, pcWrData, pcOut;
  logic        wideWrEn, narrowWrEn, ctlWrEn, flagWrEn, flagWrVal, pcWrEn;
  logic [3:0]  narrowRdIdx, narrowWrIdx;
  logic [31:0] narrowRdData, narrowWrData;
  logic [2:0]  flagRdSel, flagWrSel;
  logic        flagRdVal, modeOut;

  multiview_regfile u0 (
    .clk(clk), .rst(rst),
    .wideRdIdx(wideRdIdx), .wideRdData(wideRdData),
    .wideWrEn(wideWrEn), .wideWrIdx(wideWrIdx), .wideWrData(wideWrData),
    .narrowRdIdx(narrowRdIdx), .narrowRdData(narrowRdData),
    .narrowWrEn(narrowWrEn), .narrowWrIdx(narrowWrIdx), .narrowWrData(narrowWrData),
    .ctlRdIdx(ctlRdIdx), .ctlRdData(ctlRdData),
    .ctlWrEn(ctlWrEn), .ctlWrIdx(ctlWrIdx), .ctlWrData(ctlWrData),
    .flagRdSel(flagRdSel), .flagRdVal(flagRdVal),
    .flagWrEn(flagWrEn), .flagWrSel(flagWrSel), .flagWrVal(flagWrVal),
    .pcWrEn(pcWrEn), .pcWrData(pcWrData),
    .pcOut(pcOut), .modeOut(modeOut)
  );

  // behavioural reference state
  logic [63:0] mGpr [64];
  logic [63:0] mCr  [64];
  logic [31:0] mSr;
  logic [63:0] mPc;
  logic        mMode;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  function automatic int flagBit(input logic [2:0] sel);
    case (sel)
      3'd0: return 14;
      3'd1: return 13;
      3'd2: return 12;
      3'd3: return 9;
      3'd4: return 8;
      3'd5: return 1;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    wideWrEn = 0; narrowWrEn = 0; ctlWrEn = 0; flagWrEn = 0; pcWrEn = 0;
    wideWrIdx = 0; wideWrData = 0; narrowWrIdx = 0; narrowWrData = 0;
    ctlWrIdx = 0; ctlWrData = 0; flagWrSel = 0; flagWrVal = 0; pcWrData = 0;
  endtask

  // called just after a falling edge with inputs set: compare, then advance
  task automatic step(input string ctx);
    logic [63:0] expWide, expCtl;
    int fb;
    #1;
    expWide = (wideRdIdx == 6'd63) ? 64'd0 : mGpr[wideRdIdx];
    chk((wideRdIdx == 6'd63) ? "R1" : "R2", {ctx, " wideRdData"}, wideRdData, expWide);
    chk("R3", {ctx, " narrowRdData"}, {32'd0, narrowRdData}, {32'd0, mGpr[narrowRdIdx][31:0]});
    expCtl = (ctlRdIdx == 6'd0) ? {32'd0, mSr} : mCr[ctlRdIdx];
    chk((ctlRdIdx == 6'd0) ? "R6" : "R7", {ctx, " ctlRdData"}, ctlRdData, expCtl);
    fb = flagBit(flagRdSel);
    chk("R8", {ctx, " flagRdVal"}, {63'd0, flagRdVal}, {63'd0, (fb < 0) ? 1'b0 : mSr[fb]});
    chk("R11", {ctx, " pcOut"}, pcOut, mPc);
    chk("R12", {ctx, " modeOut"}, {63'd0, modeOut}, {63'd0, mMode});
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 64; i++) begin mGpr[i] = 0; mCr[i] = 0; end
      mSr = 0; mPc = 0; mMode = 0;
    end else begin
      if (wideWrEn && wideWrIdx != 6'd63) mGpr[wideWrIdx] = wideWrData;
      if (narrowWrEn) mGpr[narrowWrIdx] = {{32{narrowWrData[31]}}, narrowWrData};
      if (ctlWrEn) begin
        if (ctlWrIdx == 6'd0) mSr = ctlWrData[31:0];
        else mCr[ctlWrIdx] = ctlWrData;
      end
      fb = flagBit(flagWrSel);
      if (flagWrEn && fb >= 0) mSr[fb] = flagWrVal;
      if (pcWrEn) begin mPc = {pcWrData[63:1], 1'b0}; mMode = pcWrData[0]; end
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mGpr[i] = 'x; mCr[i] = 'x; end
    mSr = 'x; mPc = 'x; mMode = 'x;
    idle();
    rst = 1;
    wideRdIdx = 0; narrowRdIdx = 0; ctlRdIdx = 0; flagRdSel = 0;
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    // R13: reset state
    for (int i = 0; i < 64; i++) begin mGpr[i] = 0; mCr[i] = 0; end
    mSr = 0; mPc = 0; mMode = 0;
    step("reset");
    rst = 0;
    wideRdIdx = 6'd9; ctlRdIdx = 6'd4; narrowRdIdx = 4'd9;
    step("R13 after reset");

    // R2: full-width write then read
    wideWrEn = 1; wideWrIdx = 6'd5; wideWrData = 64'h1122_3344_5566_7788;
    wideRdIdx = 6'd5;
    step("R2 write");
    idle();
    step("R2 readback");

    // R1: write to entry 63 discarded
    wideWrEn = 1; wideWrIdx = 6'd63; wideWrData = '1; wideRdIdx = 6'd63;
    step("R1 write");
    idle();
    step("R1 readback");
    chk("R1", "entry 63", wideRdData, 64'd0);

    // R4/R3: negative and positive half-width writes
    narrowWrEn = 1; narrowWrIdx = 4'd3; narrowWrData = 32'h8000_0001;
    wideRdIdx = 6'd3; narrowRdIdx = 4'd3;
    step("R4 neg write");
    narrowWrIdx = 4'd2; narrowWrData = 32'h7FFF_0000;
    step("R4 neg read");
    chk("R4", "neg sign ext", wideRdData, 64'hFFFF_FFFF_8000_0001);
    idle(); wideRdIdx = 6'd2; narrowRdIdx = 4'd2;
    step("R4 pos read");
    chk("R4", "pos sign ext", wideRdData, 64'h0000_0000_7FFF_0000);
    wideWrEn = 1; wideWrIdx = 6'd10; wideWrData = 64'hCAFE_F00D_1234_ABCD;
    narrowRdIdx = 4'd10;
    step("R3 prep");
    idle();
    step("R3 low half");
    chk("R3", "low half", {32'd0, narrowRdData}, 64'h1234_ABCD);

    // R5: collision between both paths
    wideWrEn = 1; wideWrIdx = 6'd4; wideWrData = 64'hAAAA_AAAA_AAAA_AAAA;
    narrowWrEn = 1; narrowWrIdx = 4'd4; narrowWrData = 32'h1234_5678;
    wideRdIdx = 6'd4;
    step("R5 collide");
    idle();
    step("R5 readback");
    chk("R5", "half-width wins", wideRdData, 64'h0000_0000_1234_5678);

    // R6: status window, upper data bits dropped
    ctlWrEn = 1; ctlWrIdx = 6'd0; ctlWrData = 64'hFFFF_FFFF_DEAD_BEEF; ctlRdIdx = 6'd0;
    step("R6 write");
    idle();
    step("R6 readback");
    chk("R6", "zero-extended status", ctlRdData, 64'h0000_0000_DEAD_BEEF);

    // R7: ordinary control register
    ctlWrEn = 1; ctlWrIdx = 6'd7; ctlWrData = 64'h0BAD_F00D_5555_0001; ctlRdIdx = 6'd7;
    step("R7 write");
    idle();
    step("R7 readback");
    chk("R7", "cr7", ctlRdData, 64'h0BAD_F00D_5555_0001);

    // R8/R9: each flag code, including unused codes 6 and 7
    ctlWrEn = 1; ctlWrIdx = 6'd0; ctlWrData = 64'h0; ctlRdIdx = 6'd0;
    step("R9 clear status");
    for (int s = 0; s < 8; s++) begin
      idle(); flagWrEn = 1; flagWrSel = 3'(s); flagWrVal = 1; flagRdSel = 3'(s);
      step("R9 flag set");
      idle();
      step("R8 flag read");
    end
    chk("R8", "status after flag sets", ctlRdData, 64'h0000_7302);
    idle(); flagWrEn = 1; flagWrSel = 3'd3; flagWrVal = 0; flagRdSel = 3'd3;
    step("R9 flag clear");
    idle();
    step("R9 readback");
    chk("R9", "only bit 9 cleared", ctlRdData, 64'h0000_7102);

    // R10: flag write beats same-cycle status write
    ctlWrEn = 1; ctlWrIdx = 6'd0; ctlWrData = 64'h0000_0000_0000_F0F0;
    flagWrEn = 1; flagWrSel = 3'd0; flagWrVal = 0; flagRdSel = 3'd0;
    step("R10 collide");
    idle();
    step("R10 readback");
    chk("R10", "flag bit wins", ctlRdData, 64'h0000_0000_0000_B0F0);

    // R11/R12: program counter split
    pcWrEn = 1; pcWrData = 64'h8000_0000_0000_0123;
    step("R11 odd write");
    idle();
    step("R11 readback");
    chk("R11", "pc cleared bit0", pcOut, 64'h8000_0000_0000_0122);
    chk("R11", "mode set", {63'd0, modeOut}, 64'd1);
    wideWrEn = 1; wideWrIdx = 6'd1; wideWrData = 64'h1; ctlWrEn = 1; ctlWrIdx = 6'd0; ctlWrData = '1;
    step("R12 other writes");
    idle();
    step("R12 hold");
    chk("R12", "mode held", {63'd0, modeOut}, 64'd1);
    pcWrEn = 1; pcWrData = 64'h0000_0000_0000_4000;
    step("R11 even write");
    idle();
    step("R11 even readback");

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] pick;
      pick = ($urandom_range(0, 7) == 0) ? 6'd63 : 6'($urandom_range(0, 11));
      wideWrEn = 1'($urandom);  wideWrIdx = pick; wideWrData = {$urandom, $urandom};
      narrowWrEn = 1'($urandom); narrowWrIdx = 4'($urandom_range(0, 11));
      narrowWrData = $urandom;
      ctlWrEn = 1'($urandom); ctlWrIdx = 6'($urandom_range(0, 3));
      ctlWrData = {$urandom, $urandom};
      flagWrEn = 1'($urandom); flagWrSel = 3'($urandom); flagWrVal = 1'($urandom);
      pcWrEn = ($urandom_range(0, 3) == 0); pcWrData = {$urandom, $urandom};
      wideRdIdx = ($urandom_range(0, 7) == 0) ? 6'd63 : 6'($urandom_range(0, 11));
      narrowRdIdx = 4'($urandom_range(0, 11));
      ctlRdIdx = 6'($urandom_range(0, 3));
      flagRdSel = 3'($urandom);
      rst = (n == 1500);
      step(rst ? "R13 mid reset" : "mixed");
    end
    rst = 0; idle();
    step("final");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule